// File: doc/BRIEF.md
# Motor Speed-Lock Mode Controller

This block supervises a motor speed loop. It receives a steady reference pulse train and a tachometer feedback pulse train. Both are already in the system clock domain's timing range but arrive asynchronously. The block counts feedback rising edges inside each reference period (Nv) and reference rising edges inside each feedback period (Nr). From those counts it emits three active-low pulse trains:

- a "slow" train, Nr−1 pulses, when the motor lags;
- a "fast" train, Nv−1 pulses, when the motor overruns;
- a "boost" train, Nr−1 pulses, when the motor lags and the last reference period held no feedback edge at all.

A small state machine reacts to these trains and selects the motor drive mode. The states are ST_IDLE (loop disabled), ST_DRIVE (phase-lock drive), ST_HALT (motor stopped) and ST_BOOST (full acceleration).

The transitions are:

- Enable taken high: IDLE→DRIVE.
- Any fast pulse: active state→HALT.
- A boost pulse while the lock latch is set: active state→BOOST.
- A slow pulse: HALT→DRIVE.
- Enable taken low: any state→IDLE.

A lock latch sets on the first reference window in which Nv and Nr both equal 1. Until it sets, boost pulses are ignored. This stops the slow feedback rise near synchronization from re-triggering full acceleration.

In DRIVE the drive output is a phase comparator. A reference edge turns it on and a feedback edge turns it off, so the on-time grows as the feedback lags.

Top module: `motor_lock_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the clock edge after any edge that samples `enable` low, all mode flags, `locked` and `drive_out` are 0, and `slow_n`, `fast_n` and `boost_n` are 1.
- R2: At most one of `mode_drive`, `mode_halt` and `mode_boost` is 1. One edge after `enable` is first sampled high from idle, `mode_drive` is 1.
- R3: When a feedback window closes with Nr ≥ 2, `slow_n` is low for Nr−1 consecutive cycles, starting right after the closing edge. Nr ≤ 1 gives no pulse. Counts saturate at CNT_MAX (default 15), so at most 14 pulses occur.
- R4: When a reference window closes with Nv ≥ 2, `fast_n` is low for Nv−1 consecutive cycles, starting right after the closing edge.
- R5: When a feedback window closes with Nr ≥ 2 and the reference window completed before that edge had Nv = 0, `boost_n` is low for Nr−1 consecutive cycles.
- R6: `locked` sets when a reference window closes with Nv = 1 while the last completed feedback window had Nr = 1. It then holds until `enable` is low or reset.
- R7: A low `fast_n` sampled with `enable` high puts the block in HALT at the next edge. This takes priority over boost and slow pulses in the same cycle.
- R8: A low `boost_n` moves the block to BOOST only when `locked` is 1. Otherwise it has no effect on the mode.
- R9: A low `slow_n` in HALT, with no fast or qualified boost pulse in the same cycle, returns the block to DRIVE.
- R10: In DRIVE, `drive_out` is set after a reference edge and cleared after a feedback edge, and a coincident pair clears it. In BOOST it is 1. In HALT and IDLE it is 0.
- R11: A feedback edge detected in the same cycle as a reference edge counts in the closing reference window. Likewise a reference edge counts in a closing feedback window. So in-phase trains give Nv = Nr = 1, no pulses, and a set `locked`.
- R12: A new window close for a pulse train restarts that train with the new count. A new count of 1 cancels the remaining pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Loop enable; low clears all loop state |
| ref_in | input | 1 | Reference pulse train, asynchronous |
| fb_in | input | 1 | Tachometer feedback pulse train, asynchronous |
| slow_n | output | 1 | Active-low pulses, Nr−1 per lagging feedback window |
| fast_n | output | 1 | Active-low pulses, Nv−1 per overrunning reference window |
| boost_n | output | 1 | Active-low pulses requesting full acceleration |
| mode_drive | output | 1 | Phase-lock drive mode |
| mode_halt | output | 1 | Motor stop mode |
| mode_boost | output | 1 | Full acceleration mode |
| locked | output | 1 | First 1:1 window has been seen |
| drive_out | output | 1 | Motor drive signal |

## Verification
The fast and slow pulse trains can both be low in the same cycle. This happens when an overrun reference window closes while a long slow burst from a lagging feedback window is still running. The same applies to boost and fast. The bench provokes this with runs of randomly spaced edges on both inputs. A cycle-by-cycle behavioural model applies the stated priority (fast over boost over slow) and flags any cycle where the mode differs. Directed phases also pin down the cancelling of a running burst by a 1:1 window and the ignoring of boost pulses before lock.

// File: rtl/mlc_pkg.sv
package mlc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRIVE = 2'd1,
        ST_HALT  = 2'd2,
        ST_BOOST = 2'd3
    } mlc_state_e;
endpackage

// File: rtl/mlc_edge_sync.sv
module mlc_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic s1_q, s2_q, s3_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= din;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign rise = s2_q & ~s3_q;
endmodule

// File: rtl/mlc_window_counter.sv
// Counts tick edges between successive close edges; a tick in the
// closing cycle belongs to the window that closes.
module mlc_window_counter #(
    parameter int CNT_MAX = 15,
    parameter int CW      = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          close,
    input  logic          tick,
    output logic [CW-1:0] n_now,
    output logic [CW-1:0] n_last
);
    localparam logic [CW-1:0] TOP = CW'(CNT_MAX);

    logic [CW-1:0] cnt_q;

    always_comb begin
        n_now = (cnt_q == TOP) ? cnt_q : cnt_q + CW'(tick);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            n_last <= '0;
        end else if (clr) begin
            cnt_q  <= '0;
            n_last <= '0;
        end else if (close) begin
            cnt_q  <= '0;
            n_last <= n_now;
        end else begin
            cnt_q  <= n_now;
        end
    end
endmodule

// File: rtl/mlc_burst.sv
// On load with count n, drives n-1 one-cycle low pulses back to back.
module mlc_burst #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          load,
    input  logic [CW-1:0] n,
    output logic          pulse_n
);
    localparam logic [CW-1:0] TWO = CW'(2);

    logic [CW-1:0] rem_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q   <= '0;
            pulse_n <= 1'b1;
        end else if (clr) begin
            rem_q   <= '0;
            pulse_n <= 1'b1;
        end else if (load) begin
            if (n >= TWO) begin
                rem_q   <= n - TWO;
                pulse_n <= 1'b0;
            end else begin
                rem_q   <= '0;
                pulse_n <= 1'b1;
            end
        end else if (rem_q != '0) begin
            rem_q   <= rem_q - CW'(1);
            pulse_n <= 1'b0;
        end else begin
            pulse_n <= 1'b1;
        end
    end
endmodule

// File: rtl/motor_lock_ctrl.sv
module motor_lock_ctrl
    import mlc_pkg::*;
#(
    parameter int CNT_MAX = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic ref_in,
    input  logic fb_in,
    output logic slow_n,
    output logic fast_n,
    output logic boost_n,
    output logic mode_drive,
    output logic mode_halt,
    output logic mode_boost,
    output logic locked,
    output logic drive_out
);
    localparam int CW = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] ONE = CW'(1);
    localparam logic [CW-1:0] TWO = CW'(2);

    logic          clr;
    logic [1:0]    raw_in;
    logic [1:0]    rise;
    logic          ref_rise, fb_rise;
    logic [CW-1:0] nv_now, nv_last, nr_now, nr_last;
    logic          boost_load, lock_set;
    logic          lock_q, drive_q;
    mlc_state_e    state_q, state_d;

    assign clr    = ~enable;
    assign raw_in = {fb_in, ref_in};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        mlc_edge_sync u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_in[g]),
            .rise (rise[g])
        );
    end

    assign ref_rise = rise[0];
    assign fb_rise  = rise[1];

    // Feedback edges per reference window (Nv)
    mlc_window_counter #(.CNT_MAX(CNT_MAX), .CW(CW)) u_nv (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .close(ref_rise), .tick(fb_rise),
        .n_now(nv_now), .n_last(nv_last)
    );

    // Reference edges per feedback window (Nr)
    mlc_window_counter #(.CNT_MAX(CNT_MAX), .CW(CW)) u_nr (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .close(fb_rise), .tick(ref_rise),
        .n_now(nr_now), .n_last(nr_last)
    );

    assign boost_load = fb_rise && (nr_now >= TWO) && (nv_last == '0);
    assign lock_set   = ref_rise && (nv_now == ONE) && (nr_last == ONE);

    mlc_burst #(.CW(CW)) u_slow (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .load(fb_rise), .n(nr_now), .pulse_n(slow_n)
    );

    mlc_burst #(.CW(CW)) u_fast (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .load(ref_rise), .n(nv_now), .pulse_n(fast_n)
    );

    mlc_burst #(.CW(CW)) u_boost (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .load(boost_load), .n(nr_now), .pulse_n(boost_n)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
        end else if (clr) begin
            lock_q <= 1'b0;
        end else if (lock_set) begin
            lock_q <= 1'b1;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: fast beats boost beats slow
    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_DRIVE;
                ST_DRIVE, ST_HALT, ST_BOOST: begin
                    if (!fast_n) begin
                        state_d = ST_HALT;
                    end else if (!boost_n && lock_q) begin
                        state_d = ST_BOOST;
                    end else if (!slow_n && state_q == ST_HALT) begin
                        state_d = ST_DRIVE;
                    end
                end
            endcase
        end
    end

    // Mode outputs
    always_comb begin
        mode_drive = 1'b0;
        mode_halt  = 1'b0;
        mode_boost = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_DRIVE: mode_drive = 1'b1;
            ST_HALT:  mode_halt  = 1'b1;
            ST_BOOST: mode_boost = 1'b1;
        endcase
    end

    // Drive signal
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drive_q <= 1'b0;
        end else if (clr) begin
            drive_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_DRIVE: begin
                    if (fb_rise)       drive_q <= 1'b0;
                    else if (ref_rise) drive_q <= 1'b1;
                end
                ST_BOOST: drive_q <= 1'b1;
                ST_IDLE, ST_HALT: drive_q <= 1'b0;
            endcase
        end
    end

    assign locked    = lock_q;
    assign drive_out = drive_q;
endmodule

// File: rtl/mlc_checker.sv
module mlc_checker (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic slow_n,
    input logic fast_n,
    input logic boost_n,
    input logic mode_drive,
    input logic mode_halt,
    input logic mode_boost,
    input logic locked,
    input logic drive_out
);
    // R1
    disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!mode_drive && !mode_halt && !mode_boost && !locked &&
                     !drive_out && slow_n && fast_n && boost_n));

    // R2
    mode_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mode_drive, mode_halt, mode_boost}));

    // R7
    fast_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !fast_n) |=> mode_halt);

    // R8
    boost_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_boost |-> locked);

    // R6
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && locked) |=> locked);

    // R10
    boost_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && mode_boost) |=> drive_out);

    // R10
    halt_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_halt |=> !drive_out);
endmodule

bind motor_lock_ctrl mlc_checker u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .slow_n(slow_n), .fast_n(fast_n), .boost_n(boost_n),
    .mode_drive(mode_drive), .mode_halt(mode_halt), .mode_boost(mode_boost),
    .locked(locked), .drive_out(drive_out)
);

// File: tb/motor_lock_ctrl_bench.sv
`timescale 1ns/1ps
module motor_lock_ctrl_bench;
    localparam int MAXC = 15;

    logic clk = 1'b0;
    logic rst_n, enable, ref_in, fb_in;
    logic slow_n, fast_n, boost_n, mode_drive, mode_halt, mode_boost, locked, drive_out;

    int checks = 0;
    int errors = 0;
    int slow_lows, fast_lows, boost_lows;
    bit boost_seen;

    always #5 clk = ~clk;

    motor_lock_ctrl #(.CNT_MAX(MAXC)) u_motor_lock_ctrl (
        .clk(clk), .rst_n(rst_n), .enable(enable), .ref_in(ref_in), .fb_in(fb_in),
        .slow_n(slow_n), .fast_n(fast_n), .boost_n(boost_n),
        .mode_drive(mode_drive), .mode_halt(mode_halt), .mode_boost(mode_boost),
        .locked(locked), .drive_out(drive_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model: 0 idle, 1 drive, 2 halt, 3 boost
    logic [2:0] m_rs, m_fs;
    int m_nvc, m_nrc, m_nvl, m_nrl;
    int m_rs_rem, m_rf_rem, m_rb_rem;
    int m_slow, m_fast, m_boost, m_lock, m_st, m_drv;

    function automatic int sat(input int x);
        return (x > MAXC) ? MAXC : x;
    endfunction

    always @(posedge clk) begin
        int rr, fr, nv_now, nr_now, ld_b, lk, nst, ndrv;
        if (!rst_n) begin
            m_rs = '0; m_fs = '0;
            m_nvc = 0; m_nrc = 0; m_nvl = 0; m_nrl = 0;
            m_rs_rem = 0; m_rf_rem = 0; m_rb_rem = 0;
            m_slow = 1; m_fast = 1; m_boost = 1; m_lock = 0; m_st = 0; m_drv = 0;
        end else begin
            rr = (m_rs[1] && !m_rs[2]) ? 1 : 0;
            fr = (m_fs[1] && !m_fs[2]) ? 1 : 0;
            m_rs = {m_rs[1], m_rs[0], ref_in};
            m_fs = {m_fs[1], m_fs[0], fb_in};
            if (!enable) begin
                m_nvc = 0; m_nrc = 0; m_nvl = 0; m_nrl = 0;
                m_rs_rem = 0; m_rf_rem = 0; m_rb_rem = 0;
                m_slow = 1; m_fast = 1; m_boost = 1; m_lock = 0; m_st = 0; m_drv = 0;
            end else begin
                nv_now = sat(m_nvc + fr);
                nr_now = sat(m_nrc + rr);
                ld_b = (fr == 1 && nr_now >= 2 && m_nvl == 0) ? 1 : 0;
                lk = (rr == 1 && nv_now == 1 && m_nrl == 1) ? 1 : 0;
                // mode from previous-cycle pulses
                if (m_st == 0) nst = 1;
                else if (m_fast == 0) nst = 2;
                else if (m_boost == 0 && m_lock == 1) nst = 3;
                else if (m_slow == 0 && m_st == 2) nst = 1;
                else nst = m_st;
                if (m_st == 1) ndrv = fr ? 0 : (rr ? 1 : m_drv);
                else if (m_st == 3) ndrv = 1;
                else ndrv = 0;
                m_st = nst; m_drv = ndrv;
                m_nvc = rr ? 0 : nv_now;
                m_nrc = fr ? 0 : nr_now;
                if (rr) m_nvl = nv_now;
                if (fr) m_nrl = nr_now;
                // bursts
                if (fr) begin
                    m_slow = (nr_now >= 2) ? 0 : 1; m_rs_rem = (nr_now >= 2) ? nr_now - 2 : 0;
                end else if (m_rs_rem > 0) begin m_slow = 0; m_rs_rem--; end
                else m_slow = 1;
                if (rr) begin
                    m_fast = (nv_now >= 2) ? 0 : 1; m_rf_rem = (nv_now >= 2) ? nv_now - 2 : 0;
                end else if (m_rf_rem > 0) begin m_fast = 0; m_rf_rem--; end
                else m_fast = 1;
                if (ld_b) begin
                    m_boost = 0; m_rb_rem = nr_now - 2;
                end else if (m_rb_rem > 0) begin m_boost = 0; m_rb_rem--; end
                else m_boost = 1;
                if (lk) m_lock = 1;
            end
        end
        #1;
        chk("R3 slow_n", slow_n, m_slow);
        chk("R4 fast_n", fast_n, m_fast);
        chk("R5 boost_n", boost_n, m_boost);
        chk("R6 locked", locked, m_lock);
        chk("R2 mode_drive", mode_drive, m_st == 1);
        chk("R7 mode_halt", mode_halt, m_st == 2);
        chk("R8 mode_boost", mode_boost, m_st == 3);
        chk("R10 drive_out", drive_out, m_drv);
        if (!slow_n) slow_lows++;
        if (!fast_n) fast_lows++;
        if (!boost_n) boost_lows++;
        if (mode_boost) boost_seen = 1;
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input bit r, input bit f, input int hi, input int lo);
        ref_in = r; fb_in = f;
        idle(hi);
        ref_in = 0; fb_in = 0;
        idle(lo);
    endtask

    task automatic clear_counts();
        slow_lows = 0; fast_lows = 0; boost_lows = 0; boost_seen = 0;
    endtask

    task automatic restart();
        enable = 0; ref_in = 0; fb_in = 0;
        idle(5);
        enable = 1;
        idle(2);
        clear_counts();
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; enable = 0; ref_in = 0; fb_in = 0;
        clear_counts();
        idle(3);
        rst_n = 1;
        idle(2);
        // R1 reset / disabled state
        chk("R1 modes", {mode_drive, mode_halt, mode_boost}, 0);
        chk("R1 pulses", {slow_n, fast_n, boost_n}, 3'b111);
        chk("R1 drive/lock", {drive_out, locked}, 0);

        restart();
        chk("R2 enable enters drive", mode_drive, 1);

        // Lagging feedback before lock: 4 refs in one feedback window
        pulse(0, 1, 2, 2);
        repeat (4) pulse(1, 0, 2, 2);
        pulse(0, 1, 2, 2);
        idle(20);
        chk("R3 slow pulse count", slow_lows, 3);
        chk("R5 boost pulse count", boost_lows, 3);
        chk("R8 boost ignored before lock", boost_seen, 0);

        // Saturation: 20 refs in one feedback window
        restart();
        pulse(0, 1, 2, 2);
        repeat (20) pulse(1, 0, 2, 2);
        pulse(0, 1, 2, 2);
        idle(30);
        chk("R3 saturated slow count", slow_lows, MAXC - 1);

        // Restart of a running burst by a 1:1 window
        restart();
        pulse(0, 1, 2, 2);
        repeat (6) pulse(1, 0, 2, 2);
        pulse(0, 1, 1, 1);
        pulse(1, 1, 1, 1);
        idle(20);
        chk("R12 slow burst cut short", slow_lows, 2);

        // Overrun: 3 feedback edges in one reference window
        restart();
        pulse(1, 0, 2, 2);
        repeat (3) pulse(0, 1, 2, 2);
        pulse(1, 0, 2, 2);
        idle(12);
        chk("R4 fast pulse count", fast_lows, 2);
        chk("R7 halt after fast", mode_halt, 1);

        // Slow pulses leave halt, boost still ignored
        clear_counts();
        repeat (2) pulse(1, 0, 2, 2);
        pulse(0, 1, 2, 2);
        idle(12);
        chk("R9 slow returns to drive", mode_drive, 1);
        chk("R9 slow pulse count", slow_lows, 2);
        chk("R8 no boost while unlocked", boost_seen, 0);

        // In-phase trains lock
        restart();
        repeat (3) pulse(1, 1, 2, 2);
        idle(10);
        chk("R11 coincident no slow", slow_lows, 0);
        chk("R11 coincident no fast", fast_lows, 0);
        chk("R6 lock latched", locked, 1);

        // Lag after lock: boost accepted
        pulse(0, 1, 2, 2);
        repeat (4) pulse(1, 0, 2, 2);
        pulse(0, 1, 2, 2);
        idle(3);
        chk("R8 boost after lock", mode_boost, 1);
        chk("R10 boost drives", drive_out, 1);
        chk("R6 lock held", locked, 1);

        // Disable clears everything
        enable = 0;
        idle(1);
        chk("R1 disable modes", {mode_drive, mode_halt, mode_boost}, 0);
        chk("R1 disable lock/drive", {locked, drive_out}, 0);

        // Randomly spaced edges for collisions, compared cycle by cycle
        restart();
        for (int i = 0; i < 400; i++) begin
            pulse(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                  $urandom_range(1, 3), $urandom_range(1, 3));
        end
        idle(20);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule